// File: doc/BRIEF.md
# Self-Clocked Serial ADC Frame Receiver

This block receives result frames from a converter that drives its own serial clock. Only two lines are used: clock and data, both outputs of the converter. Chip select stays low all the time. Both lines idle HIGH while a conversion runs. When the result is ready, the converter pulls both lines LOW. It then sends 24 clock pulses and changes data on each falling clock edge. After the last pulse it releases data HIGH again to start the next conversion.

The receiver brings both lines into the system clock domain through synchronisers and finds clock rising edges on the synchronised copy. It shifts the frame in MSB first and checks the leading flag bit and the release of the data line at the end of the frame. It then offers the sign and the magnitude, with an error flag, on a valid/ready output register. Two programmable windows catch faults. One covers a frame that stops short, which raises a timeout pulse. The other covers a data line that never returns HIGH, which raises the frame error. A frame that completes while the previous one is still unaccepted is dropped and counted.

Top module: `adc_frame_rx`

## Requirements
- R1: After reset, frame_valid_o, timeout_o and overrun_cnt_o are all 0.
- R2: A frame starts only once both sck_i and sdo_i are seen LOW while idle. Clock activity with sdo_i held HIGH produces neither a frame nor a timeout.
- R3: sdo_i is sampled on each sck_i rising edge, MSB first, for 24 edges. Frame bit 21 appears on sign_o and frame bits 20..0 appear on mag_o, with bit 20 as the MSB.
- R4: frame_err_o is 1 when the first captured bit (frame bit 23, the end-of-conversion flag) is 1, and 0 otherwise when the frame ends normally.
- R5: If sdo_i is not HIGH within TAIL_WIN system clocks after the 24th edge, the frame is still presented, with frame_err_o = 1.
- R6: If fewer than 24 edges arrive within FRAME_WIN system clocks of the frame start, timeout_o pulses HIGH for one cycle and no frame is presented. The receiver then waits for the next end of conversion.
- R7: While frame_valid_o is 1 and frame_ready_i is 0, frame_valid_o, sign_o, mag_o and frame_err_o hold. A cycle with frame_ready_i = 1 clears frame_valid_o on the next clock.
- R8: A frame that completes while frame_valid_o = 1 and frame_ready_i = 0 is discarded, the held frame is kept, and overrun_cnt_o increases by one.
- R9: When sdo_i rises at the end of a frame, frame_valid_o goes HIGH on the third rising clk_i edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock driven by the converter |
| sdo_i | input | 1 | Serial data from the converter |
| frame_ready_i | input | 1 | Consumer accepts the held frame |
| frame_valid_o | output | 1 | A frame is held for the consumer |
| sign_o | output | 1 | Sign bit of the held frame |
| mag_o | output | 21 | Magnitude field of the held frame |
| frame_err_o | output | 1 | Flag bit set or data line not released |
| timeout_o | output | 1 | One-cycle pulse when a frame stops short |
| overrun_cnt_o | output | 8 | Number of frames dropped, saturating |

## Verification
A change on sdo_i or sck_i reaches the logic two edges later, through the synchroniser. The frame register then loads on the next edge, so frame_valid_o rises on the third edge after the data line is released. The bench checks this at the negative edges after edge two and edge three. The bench drives inputs on negative edges and holds each serial clock phase for at least four system clocks, so every edge is detected before the next one. Results are read only after a settling margin. A timeout pulse falls FRAME_WIN cycles after the frame start is seen. The bench counts these pulses on its own, so it needs no exact sampling point for them. A ready handshake clears frame_valid_o at the following edge, and the bench checks it one cycle later.

// File: rtl/adc_rx_pkg.sv
package adc_rx_pkg;
  typedef enum logic [1:0] {
    ST_BUSY  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TAIL  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/adc_bit_sync.sv
module adc_bit_sync #(
  parameter int          W         = 2,
  parameter int          STAGES    = 2,
  parameter logic [W-1:0] RESET_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RESET_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= RESET_VAL;
      else         chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm import adc_rx_pkg::*; #(
  parameter int FRAME_BITS = 24,
  parameter int FRAME_WIN  = 400,
  parameter int TAIL_WIN   = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sck_i,
  input  logic                  sdo_i,
  output logic                  done_o,
  output logic                  err_o,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  timeout_o
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int WMAX  = (FRAME_WIN > TAIL_WIN) ? FRAME_WIN : TAIL_WIN;
  localparam int TMR_W = $clog2(WMAX + 1);

  rx_state_e             state_q, state_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [TMR_W-1:0]      tmr_q, tmr_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  sck_d_q, tout_q, tout_d, rise;

  assign rise = sck_i & ~sck_d_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    tmr_d   = tmr_q;
    sh_d    = sh_q;
    tout_d  = 1'b0;
    done_o  = 1'b0;
    err_o   = 1'b0;
    unique case (state_q)
      ST_BUSY: begin
        if (!sck_i && !sdo_i) begin
          state_d = ST_SHIFT;
          cnt_d   = '0;
          tmr_d   = '0;
        end
      end
      ST_SHIFT: begin
        tmr_d = tmr_q + 1'b1;
        if (rise) begin
          sh_d = {sh_q[FRAME_BITS-2:0], sdo_i};
          if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
            state_d = ST_TAIL;
            tmr_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (tmr_q == TMR_W'(FRAME_WIN - 1)) begin
          tout_d  = 1'b1;
          state_d = ST_BUSY;
        end
      end
      ST_TAIL: begin
        tmr_d = tmr_q + 1'b1;
        if (sdo_i) begin
          done_o  = 1'b1;
          err_o   = sh_q[FRAME_BITS-1];
          state_d = ST_BUSY;
        end else if (tmr_q == TMR_W'(TAIL_WIN - 1)) begin
          done_o  = 1'b1;
          err_o   = 1'b1;
          state_d = ST_BUSY;
        end
      end
      default: state_d = ST_BUSY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BUSY;
      cnt_q   <= '0;
      tmr_q   <= '0;
      sh_q    <= '0;
      sck_d_q <= 1'b1;
      tout_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      tmr_q   <= tmr_d;
      sh_q    <= sh_d;
      sck_d_q <= sck_i;
      tout_q  <= tout_d;
    end
  end

  assign frame_o   = sh_q;
  assign timeout_o = tout_q;

  a_r6_timeout_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_q |=> !tout_q);
  a_r6_timeout_from_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_q) |-> $past(state_q) == ST_SHIFT);
  a_r2_start_on_eoc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && $past(state_q) == ST_BUSY) |-> (!$past(sck_i) && !$past(sdo_i)));
  a_r3_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_BITS - 1));
  a_r5_tail_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TAIL) |-> (tmr_q < TMR_W'(TAIL_WIN)));
endmodule

// File: rtl/adc_frame_out.sv
module adc_frame_out #(
  parameter int FRAME_BITS = 24,
  parameter int SIGN_POS   = 21,
  parameter int OVR_W      = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  done_i,
  input  logic                  err_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  input  logic                  ready_i,
  output logic                  valid_o,
  output logic                  sign_o,
  output logic [SIGN_POS-1:0]   mag_o,
  output logic                  err_o,
  output logic [OVR_W-1:0]      overrun_o
);
  logic load, drop;

  assign load = done_i && (!valid_o || ready_i);
  assign drop = done_i && valid_o && !ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sign_o    <= 1'b0;
      mag_o     <= '0;
      err_o     <= 1'b0;
      overrun_o <= '0;
    end else begin
      if (load) begin
        valid_o <= 1'b1;
        sign_o  <= frame_i[SIGN_POS];
        mag_o   <= frame_i[SIGN_POS-1:0];
        err_o   <= err_i;
      end else if (ready_i) begin
        valid_o <= 1'b0;
      end
      if (drop && overrun_o != '1) overrun_o <= overrun_o + 1'b1;
    end
  end

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(sign_o) && $stable(mag_o) && $stable(err_o)));
  a_r8_overrun_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && valid_o && !ready_i) |=> overrun_o != '0);
  a_r8_overrun_still: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(overrun_o));
endmodule

// File: rtl/adc_frame_rx.sv
module adc_frame_rx #(
  parameter int FRAME_BITS  = 24,
  parameter int SIGN_POS    = 21,
  parameter int FRAME_WIN   = 400,
  parameter int TAIL_WIN    = 16,
  parameter int OVR_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int MAG_W      = SIGN_POS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             sdo_i,
  input  logic             frame_ready_i,
  output logic             frame_valid_o,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             frame_err_o,
  output logic             timeout_o,
  output logic [OVR_W-1:0] overrun_cnt_o
);
  logic [1:0]            line_s;
  logic                  done, err;
  logic [FRAME_BITS-1:0] frame;

  adc_bit_sync #(.W(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, sdo_i}),
    .q_o   (line_s)
  );

  adc_frame_fsm #(
    .FRAME_BITS(FRAME_BITS), .FRAME_WIN(FRAME_WIN), .TAIL_WIN(TAIL_WIN)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sck_i    (line_s[1]),
    .sdo_i    (line_s[0]),
    .done_o   (done),
    .err_o    (err),
    .frame_o  (frame),
    .timeout_o(timeout_o)
  );

  adc_frame_out #(
    .FRAME_BITS(FRAME_BITS), .SIGN_POS(SIGN_POS), .OVR_W(OVR_W)
  ) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .done_i   (done),
    .err_i    (err),
    .frame_i  (frame),
    .ready_i  (frame_ready_i),
    .valid_o  (frame_valid_o),
    .sign_o   (sign_o),
    .mag_o    (mag_o),
    .err_o    (frame_err_o),
    .overrun_o(overrun_cnt_o)
  );

  a_r1_timeout_vs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> $stable(overrun_cnt_o));
endmodule

// File: tb/adc_frame_rx_test.sv
`timescale 1ns/1ps
module adc_frame_rx_test;
  localparam int FRAME_WIN = 400;
  localparam int TAIL_WIN  = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sck = 1'b1, sdo = 1'b1, ready = 1'b0;
  logic        valid, sign, ferr, tout;
  logic [20:0] mag;
  logic [7:0]  ovr;
  int checks = 0, fails = 0, tout_seen = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n && tout) tout_seen <= tout_seen + 1;

  adc_frame_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .sdo_i(sdo),
    .frame_ready_i(ready), .frame_valid_o(valid), .sign_o(sign),
    .mag_o(mag), .frame_err_o(ferr), .timeout_o(tout), .overrun_cnt_o(ovr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_sign(input logic [23:0] f); return f[21]; endfunction
  function automatic logic [20:0] exp_mag(input logic [23:0] f); return f[20:0]; endfunction

  task automatic send(input logic [23:0] f, input int half, input int edges,
                      input bit tail_ok, input bit lat_chk);
    sck = 1'b0; sdo = 1'b0; step(half);
    for (int i = 0; i < edges; i++) begin
      sck = 1'b0; sdo = f[23-i]; step(half);
      sck = 1'b1; step(half);
    end
    if (edges < 24) begin
      sck = 1'b1; sdo = 1'b1;
    end else if (tail_ok) begin
      sdo = 1'b1;
      if (lat_chk) begin
        step(2); chk("R9 valid low before third edge", 32'(valid), 32'd0);
        step(1); chk("R9 valid on third edge", 32'(valid), 32'd1);
      end else step(4);
    end else begin
      sdo = 1'b0; step(TAIL_WIN + 6); sdo = 1'b1; step(2);
    end
  endtask

  task automatic take(input string req, input logic [23:0] f, input logic e);
    chk({req, " valid"}, 32'(valid), 32'd1);
    chk({req, " sign"}, 32'(sign), 32'(exp_sign(f)));
    chk({req, " mag"}, 32'(mag), 32'(exp_mag(f)));
    chk({req, " err"}, 32'(ferr), 32'(e));
    ready = 1'b1; step(1); ready = 1'b0;
    chk("R7 valid cleared after ready", 32'(valid), 32'd0);
  endtask

  initial begin
    #500000;
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [23:0] f;
    int h;
    void'($urandom(32'd2024));
    step(3); rst_n = 1'b1; step(2);
    // R1
    chk("R1 valid", 32'(valid), 32'd0);
    chk("R1 timeout", 32'(tout), 32'd0);
    chk("R1 overrun", 32'(ovr), 32'd0);

    // R2: clock activity with data high is not an end of conversion
    step(40);
    for (int i = 0; i < 10; i++) begin sck = 1'b0; step(4); sck = 1'b1; step(4); end
    step(FRAME_WIN + 20);
    chk("R2 no frame", 32'(valid), 32'd0);
    chk("R2 no timeout", 32'(tout_seen), 32'd0);

    // R3/R9/R7 directed frame, bit0 low so the release is visible
    f = 24'h25A5A4;
    send(f, 4, 24, 1'b1, 1'b1);
    step(20);
    chk("R7 still held", 32'(valid), 32'd1);
    take("R3 directed", f, 1'b0);

    // R4 flag bit set
    f = 24'hC00010;
    send(f, 5, 24, 1'b1, 1'b0); step(3);
    take("R4 flag", f, 1'b1);

    // R5 data line never released in time
    f = 24'h1FFFFE;
    send(f, 4, 24, 1'b0, 1'b0); step(3);
    take("R5 tail", f, 1'b1);

    // R6 short frame
    send(24'h0ABCDE, 4, 10, 1'b1, 1'b0);
    step(FRAME_WIN + 20);
    chk("R6 timeout pulse count", 32'(tout_seen), 32'd1);
    chk("R6 no frame", 32'(valid), 32'd0);
    f = 24'h1F0F0E;
    send(f, 4, 24, 1'b1, 1'b0); step(3);
    take("R6 recovery", f, 1'b0);

    // R8 overrun
    send(24'h112230, 4, 24, 1'b1, 1'b0); step(3);
    send(24'h2AAAA8, 4, 24, 1'b1, 1'b0); step(3);
    chk("R8 overrun count", 32'(ovr), 32'd1);
    take("R8 first kept", 24'h112230, 1'b0);

    // random frames
    for (int n = 0; n < 10; n++) begin
      f = 24'($urandom);
      f[23] = ($urandom % 4 == 0);
      h = 4 + int'($urandom % 4);
      send(f, h, 24, 1'b1, 1'b0); step(3);
      take("R3 random", f, f[23]);
    end
    chk("R8 no further overrun", 32'(ovr), 32'd1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule